// File: doc/BRIEF.md
# Dual-Sided Processor Mailbox

This block lets two processors exchange 32-bit words and doorbell events. Each processor reaches it through its own simple register port, called side A and side B. On each side there are four outgoing data slots. Whatever one side writes to outgoing slot n shows up as incoming slot n on the other side. For every slot, a pair of flags shows whether the slot is free to write and whether it holds unread data. The two sides keep each other's flags in step.

Each side can also ring any of four doorbells on the other side. A doorbell stays pending until software on the receiving side clears it by writing a one. Every flag has its own enable bit, and the enabled flags are ORed into one interrupt line per side. Either side can start a short reset that returns both sides to their reset state. Status bit 7 shows while that reset is running.

Top module: `dual_msg_unit`

## Requirements
- R1: After reset, each side's status word (offset 0x20) reads 0x00F00000. That is, all four transmit-empty bits (bit 20+(3-n) for slot n) are 1, and all receive-full bits (24+(3-n)) and doorbell-pending bits (28+(3-n)) are 0. Each control word (offset 0x24) reads 0, and both interrupt lines are low.
- R2: A write to outgoing slot n (offset 4n) clears the writer's transmit-empty bit n and sets the peer's receive-full bit n, both at the edge of the write.
- R3: A read of incoming slot n (offset 0x10+4n) while its receive-full bit is set returns the word the peer last wrote to slot n. It clears that receive-full bit and sets the peer's transmit-empty bit n.
- R4: A read of an incoming slot whose receive-full bit is clear returns the last word held in that slot and changes no flag.
- R5: The two directions are independent. Words written by A reach only B, words written by B reach only A, and neither overwrites the other.
- R6: Writing 1 to control bit 16+(3-n) raises a one-cycle request. It reads back as 1 in the next cycle, then clears itself, and sets the peer's doorbell-pending bit n. Writing 0 there leaves a pending doorbell set.
- R7: Writing 1 to status bit 28+(3-n) clears the writer's own doorbell-pending bit n. Writing 0 leaves it set.
- R8: A side's interrupt is high when any of its flags is set together with its enable. The enables sit in the control word: transmit-empty n at bit 20+(3-n), receive-full n at 24+(3-n), and doorbell n at 28+(3-n).
- R9: Writing 1 to control bit 5 on either side resets both sides to the R1 state, with data slots reading 0. For RST_CYCLES cycles after that write, status bit 7 and control bit 5 read 1 and writes to either side are ignored. After that, status bit 7 reads 0.
- R10: Read data appears on the port one cycle after the access and holds until the next read. Misaligned addresses and addresses past 0x24 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rstN | input | 1 | Asynchronous reset, active low |
| aValid | input | 1 | Side A access strobe |
| aWrite | input | 1 | Side A write (1) or read (0) |
| aAddr | input | ADDR_W | Side A byte address |
| aWdata | input | DATA_W | Side A write data |
| aRdata | output | DATA_W | Side A read data, registered |
| aIrq | output | 1 | Side A combined interrupt |
| bValid | input | 1 | Side B access strobe |
| bWrite | input | 1 | Side B write (1) or read (0) |
| bAddr | input | ADDR_W | Side B byte address |
| bWdata | input | DATA_W | Side B write data |
| bRdata | output | DATA_W | Side B read data, registered |
| bIrq | output | 1 | Side B combined interrupt |

## Verification
A write changes the flags at the clock edge where it is accepted, so the interrupt lines follow right after that edge. A read returns data that was captured at its own edge. As a result, a status read issued on the cycle after a write already shows the change. A doorbell request takes one extra edge to reach the peer, so the peer's pending bit is due two edges after the control write. The reset-busy window spans RST_CYCLES edges after the reset write. Each bench task drives an access before an edge and samples one nanosecond after it, and it inserts idle cycles wherever a result is due later than that edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NREG = 4;
  localparam int IDX_W = $clog2(NREG);
  localparam int RST_CTRL_BIT = 5;
  localparam int BUSY_STAT_BIT = 7;
  localparam int WORD_STAT = 2 * NREG;
  localparam int WORD_CTRL = 2 * NREG + 1;

  typedef enum logic [2:0] {
    RD_NONE, RD_TX, RD_RX, RD_STAT, RD_CTRL, RD_ZERO
  } rdKind_t;

  typedef struct packed {
    logic [NREG-1:0] txWr;
    logic [NREG-1:0] rxRd;
    logic            statWr;
    logic            ctrlWr;
    logic            rstReq;
    rdKind_t         rdKind;
    logic [IDX_W-1:0] rdIdx;
  } sideStb_t;

  function automatic int teBit(input int n);
    return 20 + (NREG - 1 - n);
  endfunction
  function automatic int rfBit(input int n);
    return 24 + (NREG - 1 - n);
  endfunction
  function automatic int gipBit(input int n);
    return 28 + (NREG - 1 - n);
  endfunction
  function automatic int girBit(input int n);
    return 16 + (NREG - 1 - n);
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rstBit,
  output sideStb_t          stb
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    stb = '0;
    stb.rdKind = RD_NONE;
    if (valid) begin
      if (!aligned) begin
        if (!write) stb.rdKind = RD_ZERO;
      end else if (word < WORD_W'(NREG)) begin
        if (write) stb.txWr[word[IDX_W-1:0]] = 1'b1;
        else begin
          stb.rdKind = RD_TX;
          stb.rdIdx  = word[IDX_W-1:0];
        end
      end else if (word < WORD_W'(2 * NREG)) begin
        if (!write) begin
          stb.rxRd[word[IDX_W-1:0]] = 1'b1;
          stb.rdKind = RD_RX;
          stb.rdIdx  = word[IDX_W-1:0];
        end
      end else if (word == WORD_W'(WORD_STAT)) begin
        if (write) stb.statWr = 1'b1;
        else stb.rdKind = RD_STAT;
      end else if (word == WORD_W'(WORD_CTRL)) begin
        if (write) begin
          stb.ctrlWr = 1'b1;
          stb.rstReq = rstBit;
        end else stb.rdKind = RD_CTRL;
      end else if (!write) begin
        stb.rdKind = RD_ZERO;
      end
    end
  end
endmodule

// File: rtl/mbox_rst_seq.sv
module mbox_rst_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqA,
  input  logic reqB,
  output logic busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (reqA || reqB) cnt <= CNT_W'(RST_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  sideStb_t          stbA,
  input  sideStb_t          stbB,
  input  logic [DATA_W-1:0] wdataA,
  input  logic [DATA_W-1:0] wdataB,
  input  logic              busy,
  output logic [DATA_W-1:0] rdataA,
  output logic [DATA_W-1:0] rdataB,
  output logic              irqA,
  output logic              irqB
);
  sideStb_t          stb [2];
  logic [DATA_W-1:0] wd [2];
  logic [DATA_W-1:0] rd [2];
  logic [DATA_W-1:0] txData [2][NREG];
  logic [NREG-1:0]   te [2];
  logic [NREG-1:0]   rf [2];
  logic [NREG-1:0]   gip [2];
  logic [NREG-1:0]   gir [2];
  logic [NREG-1:0]   teEn [2];
  logic [NREG-1:0]   rfEn [2];
  logic [NREG-1:0]   gipEn [2];
  logic [DATA_W-1:0] statWord [2];
  logic [DATA_W-1:0] ctrlWord [2];
  logic [1:0]        irq;
  logic              clear;

  assign stb[0] = stbA;
  assign stb[1] = stbB;
  assign wd[0]  = wdataA;
  assign wd[1]  = wdataB;
  assign clear  = stbA.rstReq | stbB.rstReq | busy;

  // Flag and slot state for both directions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < 2; s++) begin
        te[s] <= '1; rf[s] <= '0; gip[s] <= '0; gir[s] <= '0;
        teEn[s] <= '0; rfEn[s] <= '0; gipEn[s] <= '0;
        for (int n = 0; n < NREG; n++) txData[s][n] <= '0;
      end
    end else if (clear) begin
      for (int s = 0; s < 2; s++) begin
        te[s] <= '1; rf[s] <= '0; gip[s] <= '0; gir[s] <= '0;
        teEn[s] <= '0; rfEn[s] <= '0; gipEn[s] <= '0;
        for (int n = 0; n < NREG; n++) txData[s][n] <= '0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        for (int n = 0; n < NREG; n++) begin
          if (stb[s].txWr[n]) begin
            txData[s][n] <= wd[s];
            te[s][n]     <= 1'b0;
          end else if (stb[1-s].rxRd[n] && rf[1-s][n]) begin
            te[s][n] <= 1'b1;
          end
          if (stb[1-s].txWr[n]) rf[s][n] <= 1'b1;
          else if (stb[s].rxRd[n]) rf[s][n] <= 1'b0;
          if (gir[1-s][n]) gip[s][n] <= 1'b1;
          else if (stb[s].statWr && wd[s][gipBit(n)]) gip[s][n] <= 1'b0;
          gir[s][n] <= stb[s].ctrlWr && wd[s][girBit(n)];
          if (stb[s].ctrlWr) begin
            teEn[s][n]  <= wd[s][teBit(n)];
            rfEn[s][n]  <= wd[s][rfBit(n)];
            gipEn[s][n] <= wd[s][gipBit(n)];
          end
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      statWord[s] = '0;
      ctrlWord[s] = '0;
      for (int n = 0; n < NREG; n++) begin
        statWord[s][teBit(n)]  = te[s][n];
        statWord[s][rfBit(n)]  = rf[s][n];
        statWord[s][gipBit(n)] = gip[s][n];
        ctrlWord[s][teBit(n)]  = teEn[s][n];
        ctrlWord[s][rfBit(n)]  = rfEn[s][n];
        ctrlWord[s][gipBit(n)] = gipEn[s][n];
        ctrlWord[s][girBit(n)] = gir[s][n];
      end
      statWord[s][BUSY_STAT_BIT] = busy;
      ctrlWord[s][RST_CTRL_BIT]  = busy;
    end
  end

  // Registered read return per side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rd[0] <= '0;
      rd[1] <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        case (stb[s].rdKind)
          RD_TX:   rd[s] <= txData[s][stb[s].rdIdx];
          RD_RX:   rd[s] <= txData[1-s][stb[s].rdIdx];
          RD_STAT: rd[s] <= statWord[s];
          RD_CTRL: rd[s] <= ctrlWord[s];
          RD_ZERO: rd[s] <= '0;
          default: rd[s] <= rd[s];
        endcase
      end
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_irq
    assign irq[s] = |(te[s] & teEn[s]) | |(rf[s] & rfEn[s]) | |(gip[s] & gipEn[s]);
  end

  assign rdataA = rd[0];
  assign rdataB = rd[1];
  assign irqA   = irq[0];
  assign irqB   = irq[1];
endmodule

// File: rtl/dual_msg_unit.sv
module dual_msg_unit
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aValid,
  input  logic              aWrite,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic              aIrq,
  input  logic              bValid,
  input  logic              bWrite,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata,
  output logic              bIrq
);
  logic              vArr [2];
  logic              wArr [2];
  logic [ADDR_W-1:0] adArr [2];
  logic              rbArr [2];
  sideStb_t          stb [2];
  logic              busy;

  assign vArr[0]  = aValid;
  assign vArr[1]  = bValid;
  assign wArr[0]  = aWrite;
  assign wArr[1]  = bWrite;
  assign adArr[0] = aAddr;
  assign adArr[1] = bAddr;
  assign rbArr[0] = aWdata[RST_CTRL_BIT];
  assign rbArr[1] = bWdata[RST_CTRL_BIT];

  for (genvar s = 0; s < 2; s++) begin : g_side
    mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .valid (vArr[s]),
      .write (wArr[s]),
      .addr  (adArr[s]),
      .rstBit(rbArr[s]),
      .stb   (stb[s])
    );
  end

  mbox_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk (clk),
    .rstN(rstN),
    .reqA(stb[0].rstReq),
    .reqB(stb[1].rstReq),
    .busy(busy)
  );

  mbox_dp #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stbA  (stb[0]),
    .stbB  (stb[1]),
    .wdataA(aWdata),
    .wdataB(bWdata),
    .busy  (busy),
    .rdataA(aRdata),
    .rdataB(bRdata),
    .irqA  (aIrq),
    .irqB  (bIrq)
  );
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              rstAny,
  input logic [NREG-1:0]   bTxWr,
  input rdKind_t           aRdKind,
  input logic [IDX_W-1:0]  aRdIdx,
  input logic [DATA_W-1:0] aRdata,
  input logic [DATA_W-1:0] bWdata,
  input logic              aIrq,
  input logic              bIrq
);
  assert_rst_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstAny |=> busy);

  assert_irq_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstAny |=> (!aIrq && !bIrq));

  assert_busy_visible_R9: assert property (@(posedge clk) disable iff (!rstN)
    (aRdKind == RD_STAT && busy) |=> aRdata[BUSY_STAT_BIT]);

  assert_busy_gone_R9: assert property (@(posedge clk) disable iff (!rstN)
    (aRdKind == RD_STAT && !busy) |=> !aRdata[BUSY_STAT_BIT]);

  assert_zero_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (aRdKind == RD_ZERO) |=> (aRdata == '0));

  for (genvar n = 0; n < NREG; n++) begin : g_slot
    assert_rx_data_R3: assert property (@(posedge clk) disable iff (!rstN)
      (bTxWr[n] && !busy && !rstAny) ##1 (aRdKind == RD_RX && aRdIdx == IDX_W'(n))
      |=> (aRdata == $past(bWdata, 2)));
  end
endmodule

bind dual_msg_unit mbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .rstAny (stb[0].rstReq | stb[1].rstReq),
  .bTxWr  (stb[1].txWr),
  .aRdKind(stb[0].rdKind),
  .aRdIdx (stb[0].rdIdx),
  .aRdata (aRdata),
  .bWdata (bWdata),
  .aIrq   (aIrq),
  .bIrq   (bIrq)
);

// File: tb/tb_dual_msg_unit.sv
`timescale 1ns/1ps
module tb_dual_msg_unit;
  localparam int RSTC = 4;
  localparam logic [31:0] IDLE_STAT = 32'h00F0_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aValid = 0, aWrite = 0, bValid = 0, bWrite = 0;
  logic [5:0] aAddr = '0, bAddr = '0;
  logic [31:0] aWdata = '0, bWdata = '0;
  logic [31:0] aRdata, bRdata;
  logic aIrq, bIrq;
  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dual_msg_unit #(.RST_CYCLES(RSTC)) dut (
    .clk(clk), .rstN(rstN),
    .aValid(aValid), .aWrite(aWrite), .aAddr(aAddr), .aWdata(aWdata),
    .aRdata(aRdata), .aIrq(aIrq),
    .bValid(bValid), .bWrite(bWrite), .bAddr(bAddr), .bWdata(bWdata),
    .bRdata(bRdata), .bIrq(bIrq)
  );

  function automatic int teB(int n); return 20 + 3 - n; endfunction
  function automatic int rfB(int n); return 24 + 3 - n; endfunction
  function automatic int gpB(int n); return 28 + 3 - n; endfunction
  function automatic int grB(int n); return 16 + 3 - n; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit side, input bit wr, input logic [5:0] ad,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    if (side) begin bValid = 1; bWrite = wr; bAddr = ad; bWdata = d; end
    else      begin aValid = 1; aWrite = wr; aAddr = ad; aWdata = d; end
    @(posedge clk); #1;
    aValid = 0; bValid = 0; aWrite = 0; bWrite = 0;
    r = side ? bRdata : aRdata;
  endtask

  task automatic wr(input bit side, input logic [5:0] ad, input logic [31:0] d);
    logic [31:0] junk;
    acc(side, 1'b1, ad, d, junk);
  endtask

  task automatic rd(input bit side, input logic [5:0] ad, output logic [31:0] r);
    acc(side, 1'b0, ad, 32'h0, r);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state;
    logic [31:0] r;
    rd(0, 6'h20, r); chk("R1 A status", r, IDLE_STAT);
    rd(1, 6'h20, r); chk("R1 B status", r, IDLE_STAT);
    rd(0, 6'h24, r); chk("R1 A control", r, 32'h0);
    rd(1, 6'h24, r); chk("R1 B control", r, 32'h0);
    chk("R1 irqs", {aIrq, bIrq}, 0);
  endtask

  task automatic t_transfer;
    logic [31:0] r;
    for (int n = 0; n < 4; n++) begin
      wr(0, 6'(4 * n), 32'hCAFE_0000 + n);
      rd(0, 6'h20, r); chk("R2 sender te cleared", r, IDLE_STAT & ~(32'h1 << teB(n)));
      rd(1, 6'h20, r); chk("R2 peer rf set", r, IDLE_STAT | (32'h1 << rfB(n)));
      rd(1, 6'(16 + 4 * n), r); chk("R3 data", r, 32'hCAFE_0000 + n);
      rd(0, 6'h20, r); chk("R3 sender te restored", r, IDLE_STAT);
      rd(1, 6'h20, r); chk("R3 rf cleared", r, IDLE_STAT);
    end
  endtask

  task automatic t_empty_read;
    logic [31:0] r;
    rd(1, 6'h18, r); chk("R4 stale data", r, 32'hCAFE_0002);
    rd(1, 6'h20, r); chk("R4 B flags unchanged", r, IDLE_STAT);
    rd(0, 6'h20, r); chk("R4 A flags unchanged", r, IDLE_STAT);
  endtask

  task automatic t_directions;
    logic [31:0] r;
    wr(0, 6'h00, 32'hAAAA_0001);
    wr(1, 6'h00, 32'hBBBB_0001);
    rd(0, 6'h10, r); chk("R5 A gets B word", r, 32'hBBBB_0001);
    rd(1, 6'h10, r); chk("R5 B gets A word", r, 32'hAAAA_0001);
    rd(0, 6'h20, r); chk("R5 A flags idle", r, IDLE_STAT);
  endtask

  task automatic t_doorbell;
    logic [31:0] r;
    wr(0, 6'h24, 32'h1 << grB(0));
    rd(0, 6'h24, r); chk("R6 request visible", r, 32'h1 << grB(0));
    rd(1, 6'h20, r); chk("R6 peer pending", r, IDLE_STAT | (32'h1 << gpB(0)));
    rd(0, 6'h24, r); chk("R6 request self-cleared", r, 32'h0);
    wr(0, 6'h24, 32'h0);
    rd(1, 6'h20, r); chk("R6 zero write no effect", r, IDLE_STAT | (32'h1 << gpB(0)));
    wr(1, 6'h20, 32'h0);
    rd(1, 6'h20, r); chk("R7 write zero keeps", r, IDLE_STAT | (32'h1 << gpB(0)));
    wr(1, 6'h20, 32'h1 << gpB(0));
    rd(1, 6'h20, r); chk("R7 write one clears", r, IDLE_STAT);
    wr(1, 6'h24, 32'h1 << grB(3));
    idle(1);
    rd(0, 6'h20, r); chk("R6 B to A slot3", r, IDLE_STAT | (32'h1 << gpB(3)));
    wr(0, 6'h20, 32'h1 << gpB(3));
  endtask

  task automatic t_irq;
    wr(0, 6'h24, 32'h1 << teB(0));
    chk("R8 te irq A", aIrq, 1);
    wr(0, 6'h00, 32'h1234);
    chk("R8 te irq drops", aIrq, 0);
    chk("R8 B no enable", bIrq, 0);
    wr(1, 6'h24, 32'h1 << rfB(0));
    chk("R8 rf irq B", bIrq, 1);
    begin
      logic [31:0] r;
      rd(1, 6'h10, r);
    end
    chk("R8 rf irq drops", bIrq, 0);
    chk("R8 te irq back", aIrq, 1);
    wr(1, 6'h24, 32'h1 << gpB(2));
    chk("R8 gip en no pending", bIrq, 0);
    wr(0, 6'h24, 32'h1 << grB(2));
    idle(1);
    chk("R8 gip irq B", bIrq, 1);
    wr(1, 6'h20, 32'h1 << gpB(2));
    chk("R8 gip irq cleared", bIrq, 0);
    wr(0, 6'h24, 32'h0);
    wr(1, 6'h24, 32'h0);
  endtask

  task automatic t_misc;
    logic [31:0] r;
    wr(0, 6'h04, 32'h0BAD_F00D);
    rd(1, 6'h14, r); chk("R10 read value", r, 32'h0BAD_F00D);
    idle(3);
    chk("R10 read data holds", bRdata, 32'h0BAD_F00D);
    rd(0, 6'h28, r); chk("R10 unmapped zero", r, 32'h0);
    rd(0, 6'h01, r); chk("R10 misaligned zero", r, 32'h0);
    wr(0, 6'h2C, 32'hFFFF_FFFF);
    wr(0, 6'h22, 32'hFFFF_FFFF);
    rd(0, 6'h20, r); chk("R10 unmapped write ignored", r, IDLE_STAT);
  endtask

  task automatic t_block_reset;
    logic [31:0] r;
    wr(0, 6'h04, 32'h1111_1111);
    wr(1, 6'h08, 32'h2222_2222);
    wr(0, 6'h24, 32'h1 << teB(3));
    chk("R9 irq before reset", aIrq, 1);
    wr(1, 6'h24, 32'h1 << 5);
    chk("R9 irq after reset", {aIrq, bIrq}, 0);
    wr(0, 6'h00, 32'h5555_5555);
    rd(0, 6'h20, r); chk("R9 busy in status", r, IDLE_STAT | 32'h80);
    rd(1, 6'h24, r); chk("R9 busy in control", r, 32'h20);
    idle(RSTC + 2);
    rd(0, 6'h20, r); chk("R9 A status after", r, IDLE_STAT);
    rd(1, 6'h20, r); chk("R9 B status after", r, IDLE_STAT);
    rd(0, 6'h24, r); chk("R9 A control after", r, 32'h0);
    rd(1, 6'h14, r); chk("R9 slot cleared", r, 32'h0);
    rd(1, 6'h10, r); chk("R9 busy write ignored", r, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog timeout");
      $display("test done: total=%0d bad=%0d", nChk + 1, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(1);
    t_reset_state();
    t_transfer();
    t_empty_read();
    t_directions();
    t_doorbell();
    t_irq();
    t_misc();
    t_block_reset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule